// File: doc/BRIEF.md
# Coprocessor Interrupt Pending and Gating Unit

This unit holds the eight interrupt-pending flags of a processor's control coprocessor and decides, every cycle, whether the core should take an interrupt. Interrupt sources raise a level with a one-cycle post request and drop it with a clear request. Software can also wipe all flags in one pulse. A request with a level number that does not exist is refused and flagged.

A free-running 32-bit count register is compared against a compare register. On a match with a nonzero count, the unit sets one pending flag, and software selects that flag through a 3-bit field in a timer-control register. Writing the compare register drops that same flag. A status register supplies the gating: a global enable, two exception-state flags (exception level and error level) and an 8-bit mask that lines up bit for bit with the pending flags.

The unit drives a registered interrupt-take request and an unmasked "something pending" indication. A read port returns any of its registers.

Top module: `cpi_unit`

## Requirements
- R1: A post request with level n in 0..7 sets pending bit n on the next clock edge and leaves the other bits unchanged.
- R2: A clear request with level n in 0..7 clears pending bit n on the next clock edge. Clearing a bit that is already zero has no effect.
- R3: A clear-all pulse zeroes all eight pending bits on the next clock edge.
- R4: A post or clear request with a level of 8 or more leaves the pending bits unchanged and raises `level_err` for the following cycle.
- R5: `irq_take` can be 1 only while status bit 0 (enable) is 1, status bit 1 (exception level) is 0 and status bit 2 (error level) is 0.
- R6: While the gating of R5 allows it, `irq_take` is 1 exactly when status bits 15:8 (mask, bit 8+k gating pending bit k) AND the pending bits give a nonzero value. `irq_take` follows status and pending changes in the same cycle that those registers update.
- R7: A timer match occurs when count equals compare and count is nonzero. Equal values with count at zero set no bit.
- R8: On a timer match, the pending bit selected by timer-control bits 2:0 is set on the next clock edge.
- R9: `irq_pending` is 1 whenever any pending bit is set, whatever the mask, enable and exception state.
- R10: When a set (post or timer match) and a clear (level clear or clear-all) hit the same bit in one cycle, the bit ends up set.
- R11: Writing the compare register clears the timer-selected pending bit on the next clock edge, unless a set hits that bit in the same cycle.
- R12: The count register increments by one on every clock edge with `cnt_en` high. A write to it takes priority over the increment, and the count is readable at read select 3.
- R13: After reset, the pending bits, `irq_take`, `level_err`, status, timer control, count and compare are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_valid | input | 1 | One-cycle post request |
| post_level | input | 4 | Level to post |
| clr_valid | input | 1 | One-cycle clear request |
| clr_level | input | 4 | Level to clear |
| clr_all | input | 1 | Clear every pending bit |
| cnt_en | input | 1 | Count register increment enable |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 status, 1 timer control, 2 compare, 3 count |
| reg_wdata | input | 32 | Write data |
| rd_sel | input | 3 | Read select: 0 status, 1 timer control, 2 compare, 3 count, 4 pending |
| rd_data | output | 32 | Read data (combinational) |
| pend_bits | output | 8 | Pending bits |
| irq_take | output | 1 | Registered interrupt-take request |
| irq_pending | output | 1 | Any pending bit set |
| level_err | output | 1 | Previous cycle carried an out-of-range level |

## Verification
A pending bit that is wrong appears on `pend_bits` one edge after the request that caused it. If its mask bit is open and gating allows, it also appears on `irq_take` at that same edge. A count or compare register that holds a wrong value only shows once a match is due: a bit is set too early, too late or not at all, one edge after the expected equality. So the bench reads count back directly before it relies on a match. Gating faults show as soon as a status write lands, because `irq_take` is recomputed from the next-state values.

// File: rtl/cpi_pkg.sv
// Package: shared encodings for the coprocessor interrupt unit.
// Assumes: status flag positions are fixed because software decodes them.
package cpi_pkg;

    // Write targets of the register port
    typedef enum logic [1:0] {
        WSEL_STATUS = 2'd0,
        WSEL_TCTL   = 2'd1,
        WSEL_CMP    = 2'd2,
        WSEL_CNT    = 2'd3
    } wsel_e;

    // Read targets of the read-back port
    typedef enum logic [2:0] {
        RSEL_STATUS = 3'd0,
        RSEL_TCTL   = 3'd1,
        RSEL_CMP    = 3'd2,
        RSEL_CNT    = 3'd3,
        RSEL_PEND   = 3'd4
    } rsel_e;

    // Status register bit positions
    localparam int ST_ENABLE = 0;
    localparam int ST_EXCL   = 1;
    localparam int ST_ERRL   = 2;
    localparam int ST_MASK_LO = 8;

endpackage

// File: rtl/cpi_timer.sv
// Module: cpi_timer
// Holds the free-running count and the compare register, and flags a
// match when both are equal and count is nonzero.
// Assumes: a count write beats the increment in the same cycle.
module cpi_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_we,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             match
);

    // Count register: load on write, else increment when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_we)
            cnt_q <= wdata;
        else if (cnt_en)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Compare register: load on write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (cmp_we)
            cmp_q <= wdata;
    end

    // Match detection, suppressed while count is zero
    always_comb begin
        match = (cnt_q == cmp_q) && (cnt_q != '0);
    end

endmodule

// File: rtl/cpi_pending.sv
// Module: cpi_pending
// Keeps the pending bits. Each bit is set by a post or a timer match and
// cleared by a level clear, clear-all or a compare write. A set wins.
// Assumes: requests are single-cycle pulses; out-of-range levels are refused.
module cpi_pending #(
    parameter int NUM_LVL = 8,
    parameter int LVL_W   = 4,
    localparam int IDX_W  = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_valid,
    input  logic [LVL_W-1:0]   post_level,
    input  logic               clr_valid,
    input  logic [LVL_W-1:0]   clr_level,
    input  logic               clr_all,
    input  logic               tmr_set,
    input  logic               tmr_clr,
    input  logic [IDX_W-1:0]   tmr_idx,
    output logic [NUM_LVL-1:0] pend_q,
    output logic [NUM_LVL-1:0] pend_next,
    output logic               lvl_err_q
);

    logic post_ok;
    logic clr_ok;

    // Range checks on requested levels
    always_comb begin
        post_ok = 32'(post_level) < NUM_LVL;
        clr_ok  = 32'(clr_level) < NUM_LVL;
    end

    // Per-bit next-state: sets override clears
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_bit
        logic set_hit;
        logic clr_hit;
        always_comb begin
            set_hit = (post_valid && post_ok && (post_level[IDX_W-1:0] == IDX_W'(i)))
                   || (tmr_set && (tmr_idx == IDX_W'(i)));
            clr_hit = clr_all
                   || (clr_valid && clr_ok && (clr_level[IDX_W-1:0] == IDX_W'(i)))
                   || (tmr_clr && (tmr_idx == IDX_W'(i)));
            pend_next[i] = set_hit || (pend_q[i] && !clr_hit);
        end
    end

    // Pending register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= pend_next;
    end

    // Error flag for any refused request in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_err_q <= 1'b0;
        else
            lvl_err_q <= (post_valid && !post_ok) || (clr_valid && !clr_ok);
    end

endmodule

// File: rtl/cpi_gate.sv
// Module: cpi_gate
// Registers the interrupt-take request from the next-state status and
// pending values, so it tracks those registers in the same cycle.
// Assumes: mask bit k lines up with pending bit k.
module cpi_gate #(
    parameter int NUM_LVL = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_n,
    input  logic               excl_n,
    input  logic               errl_n,
    input  logic [NUM_LVL-1:0] mask_n,
    input  logic [NUM_LVL-1:0] pend_n,
    output logic               take_q
);

    logic allow;

    // Global enable with both exception-state flags clear
    always_comb begin
        allow = enable_n && !excl_n && !errl_n;
    end

    // Take register: allowed and at least one unmasked pending bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            take_q <= 1'b0;
        else
            take_q <= allow && (|(mask_n & pend_n));
    end

endmodule

// File: rtl/cpi_unit.sv
// Module: cpi_unit (top)
// Coprocessor interrupt pending and gating unit: status and timer-control
// registers, timer, pending bits, take gating and read-back.
// Assumes: one register write per cycle; reads are combinational.
module cpi_unit
    import cpi_pkg::*;
#(
    parameter int NUM_LVL = 8,
    parameter int LVL_W   = 4,
    parameter int CNT_W   = 32,
    localparam int IDX_W  = $clog2(NUM_LVL),
    localparam int STAT_W = ST_MASK_LO + NUM_LVL
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_valid,
    input  logic [LVL_W-1:0]   post_level,
    input  logic               clr_valid,
    input  logic [LVL_W-1:0]   clr_level,
    input  logic               clr_all,
    input  logic               cnt_en,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [CNT_W-1:0]   reg_wdata,
    input  logic [2:0]         rd_sel,
    output logic [CNT_W-1:0]   rd_data,
    output logic [NUM_LVL-1:0] pend_bits,
    output logic               irq_take,
    output logic               irq_pending,
    output logic               level_err
);

    logic [STAT_W-1:0]  status_q;
    logic [STAT_W-1:0]  status_next;
    logic [IDX_W-1:0]   tctl_q;
    logic               st_we;
    logic               tc_we;
    logic               cmp_we;
    logic               cnt_we;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cmp_q;
    logic               tmr_match;
    logic [NUM_LVL-1:0] pend_q;
    logic [NUM_LVL-1:0] pend_next;

    // Write decode for the register port
    always_comb begin
        st_we  = reg_we && (wsel_e'(reg_sel) == WSEL_STATUS);
        tc_we  = reg_we && (wsel_e'(reg_sel) == WSEL_TCTL);
        cmp_we = reg_we && (wsel_e'(reg_sel) == WSEL_CMP);
        cnt_we = reg_we && (wsel_e'(reg_sel) == WSEL_CNT);
    end

    // Next status value, used both by the register and the gate
    always_comb begin
        status_next = st_we ? reg_wdata[STAT_W-1:0] : status_q;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= status_next;
    end

    // Timer-control register (index of the timer pending bit)
    always_ff @(posedge clk) begin
        if (!rst_n)
            tctl_q <= '0;
        else if (tc_we)
            tctl_q <= reg_wdata[IDX_W-1:0];
    end

    cpi_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .cnt_we (cnt_we),
        .cmp_we (cmp_we),
        .wdata  (reg_wdata),
        .cnt_q  (cnt_q),
        .cmp_q  (cmp_q),
        .match  (tmr_match)
    );

    cpi_pending #(
        .NUM_LVL (NUM_LVL),
        .LVL_W   (LVL_W)
    ) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_valid (post_valid),
        .post_level (post_level),
        .clr_valid  (clr_valid),
        .clr_level  (clr_level),
        .clr_all    (clr_all),
        .tmr_set    (tmr_match),
        .tmr_clr    (cmp_we),
        .tmr_idx    (tctl_q),
        .pend_q     (pend_q),
        .pend_next  (pend_next),
        .lvl_err_q  (level_err)
    );

    cpi_gate #(
        .NUM_LVL (NUM_LVL)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_n (status_next[ST_ENABLE]),
        .excl_n   (status_next[ST_EXCL]),
        .errl_n   (status_next[ST_ERRL]),
        .mask_n   (status_next[ST_MASK_LO +: NUM_LVL]),
        .pend_n   (pend_next),
        .take_q   (irq_take)
    );

    // Output drive of pending state
    always_comb begin
        pend_bits   = pend_q;
        irq_pending = |pend_q;
    end

    // Read-back multiplexer
    always_comb begin
        unique case (rsel_e'(rd_sel))
            RSEL_STATUS: rd_data = CNT_W'(status_q);
            RSEL_TCTL:   rd_data = CNT_W'(tctl_q);
            RSEL_CMP:    rd_data = cmp_q;
            RSEL_CNT:    rd_data = cnt_q;
            RSEL_PEND:   rd_data = CNT_W'(pend_q);
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cpi_unit_checker.sv
// Module: cpi_unit_checker
// Temporal checks on the interrupt unit, bound into every cpi_unit.
// Assumes: default status bit positions (enable 0, exception 1, error 2, mask 15:8).
module cpi_unit_checker #(
    parameter int NUM_LVL = 8,
    parameter int LVL_W   = 4,
    parameter int CNT_W   = 32,
    localparam int IDX_W  = $clog2(NUM_LVL),
    localparam int STAT_W = 8 + NUM_LVL
) (
    input logic               clk,
    input logic               rst_n,
    input logic               post_valid,
    input logic [LVL_W-1:0]   post_level,
    input logic               clr_valid,
    input logic               clr_all,
    input logic               cnt_en,
    input logic               cnt_we,
    input logic               tmr_match,
    input logic [STAT_W-1:0]  status_q,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [NUM_LVL-1:0] pend_bits,
    input logic               irq_take,
    input logic               irq_pending,
    input logic               level_err
);

    // R1: an in-range post shows up on the next edge
    assert_post_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && (32'(post_level) < NUM_LVL)) |=> pend_bits[$past(post_level[IDX_W-1:0])]);

    // R3: clear-all with no set in that cycle empties the field
    assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !post_valid && !tmr_match) |=> (pend_bits == '0));

    // R4: an out-of-range post is flagged
    assert_range_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && (32'(post_level) >= NUM_LVL)) |=> level_err);

    // R4: with only refused requests, pending bits hold
    assert_range_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && (32'(post_level) >= NUM_LVL) && !clr_valid && !clr_all && !tmr_match)
        |=> (pend_bits == $past(pend_bits)) || $past(cnt_we) || 1'b0);

    // R5: take only while enabled and outside exception/error levels
    assert_take_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (status_q[0] && !status_q[1] && !status_q[2]));

    // R6: take implies an unmasked pending bit
    assert_take_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (|(status_q[8 +: NUM_LVL] & pend_bits)));

    // R9: pending indication follows the pending bits alone
    assert_pending_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending == (pend_bits != '0));

    // R12: count advances by one when enabled and not written
    assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_we) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

bind cpi_unit cpi_unit_checker #(
    .NUM_LVL (NUM_LVL),
    .LVL_W   (LVL_W),
    .CNT_W   (CNT_W)
) u_cpi_unit_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .post_valid  (post_valid),
    .post_level  (post_level),
    .clr_valid   (clr_valid),
    .clr_all     (clr_all),
    .cnt_en      (cnt_en),
    .cnt_we      (cnt_we),
    .tmr_match   (tmr_match),
    .status_q    (status_q),
    .cnt_q       (cnt_q),
    .pend_bits   (pend_bits),
    .irq_take    (irq_take),
    .irq_pending (irq_pending),
    .level_err   (level_err)
);

// File: tb/cpi_unit_test.sv
// Bench for cpi_unit: vector table walk, then directed gating and timer tests.
module cpi_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_valid = 1'b0;
    logic [3:0]  post_level = '0;
    logic        clr_valid = 1'b0;
    logic [3:0]  clr_level = '0;
    logic        clr_all = 1'b0;
    logic        cnt_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [7:0]  pend_bits;
    logic        irq_take;
    logic        irq_pending;
    logic        level_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cpi_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .post_valid  (post_valid),
        .post_level  (post_level),
        .clr_valid   (clr_valid),
        .clr_level   (clr_level),
        .clr_all     (clr_all),
        .cnt_en      (cnt_en),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .pend_bits   (pend_bits),
        .irq_take    (irq_take),
        .irq_pending (irq_pending),
        .level_err   (level_err)
    );

    // Vector: op[13:12] (0 post, 1 clear, 2 clear-all), level[11:8], expected pending[7:0]
    localparam int NVEC = 12;
    localparam logic [13:0] VEC [NVEC] = '{
        {2'd0, 4'd0,  8'h01},
        {2'd0, 4'd7,  8'h81},
        {2'd0, 4'd3,  8'h89},
        {2'd1, 4'd0,  8'h88},
        {2'd0, 4'd5,  8'hA8},
        {2'd1, 4'd7,  8'h28},
        {2'd1, 4'd1,  8'h28},
        {2'd2, 4'd0,  8'h00},
        {2'd0, 4'd6,  8'h40},
        {2'd0, 4'd9,  8'h40},
        {2'd1, 4'd12, 8'h40},
        {2'd0, 4'd2,  8'h44}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock step; inputs set beforehand at a falling edge, cleared after
    task automatic step();
        @(negedge clk);
        post_valid = 1'b0;
        clr_valid  = 1'b0;
        clr_all    = 1'b0;
        reg_we     = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_we = 1'b1;
        reg_sel = sel;
        reg_wdata = d;
        step();
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        @(negedge clk);
        // R13: reset state
        chk("R13 pend", 32'(pend_bits), 32'h0);
        chk("R13 take", 32'(irq_take), 32'h0);
        chk("R13 err", 32'(level_err), 32'h0);
        rd(3'd3, v); chk("R13 count", v, 32'h0);
        rd(3'd0, v); chk("R13 status", v, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 post, R2 clear, R3 clear-all, R4 range, R9 pending
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [3:0] lv;
            logic [7:0] ex;
            op = VEC[i][13:12];
            lv = VEC[i][11:8];
            ex = VEC[i][7:0];
            if (op == 2'd0) begin post_valid = 1'b1; post_level = lv; end
            else if (op == 2'd1) begin clr_valid = 1'b1; clr_level = lv; end
            else clr_all = 1'b1;
            step();
            if (lv >= 4'd8) begin
                chk("R4 pend unchanged", 32'(pend_bits), 32'(ex));
                chk("R4 level_err", 32'(level_err), 32'h1);
            end else if (op == 2'd0) chk("R1 post", 32'(pend_bits), 32'(ex));
            else if (op == 2'd1) chk("R2 clear", 32'(pend_bits), 32'(ex));
            else chk("R3 clear-all", 32'(pend_bits), 32'(ex));
            chk("R9 pending", 32'(irq_pending), 32'(ex != 8'h0));
        end

        // R10: post and clear on the same bit; then clear-all with post
        post_valid = 1'b1; post_level = 4'd2; clr_valid = 1'b1; clr_level = 4'd2;
        step();
        chk("R10 set beats clear", 32'(pend_bits), 32'h44);
        clr_all = 1'b1; post_valid = 1'b1; post_level = 4'd4;
        step();
        chk("R10 set beats clear-all", 32'(pend_bits), 32'h10);

        // R5/R6 gating with bit 4 pending
        wr(2'd0, 32'h1001);
        chk("R6 take unmasked", 32'(irq_take), 32'h1);
        wr(2'd0, 32'h1003);
        chk("R5 exception level blocks", 32'(irq_take), 32'h0);
        wr(2'd0, 32'h1005);
        chk("R5 error level blocks", 32'(irq_take), 32'h0);
        wr(2'd0, 32'h1000);
        chk("R5 disabled blocks", 32'(irq_take), 32'h0);
        wr(2'd0, 32'h0101);
        chk("R6 masked off", 32'(irq_take), 32'h0);
        chk("R9 pending ignores mask", 32'(irq_pending), 32'h1);
        wr(2'd0, 32'h1001);
        chk("R6 take again", 32'(irq_take), 32'h1);
        clr_valid = 1'b1; clr_level = 4'd4;
        step();
        chk("R6 take drops with bit", 32'(irq_take), 32'h0);
        chk("R2 bit 4 cleared", 32'(pend_bits), 32'h0);
        wr(2'd0, 32'h0);

        // R7: equal at zero does not fire
        wr(2'd1, 32'd5);
        wr(2'd3, 32'd0);
        wr(2'd2, 32'd0);
        step();
        chk("R7 zero count no match", 32'(pend_bits), 32'h0);

        // R8: match at 7 sets bit 5
        wr(2'd3, 32'd7);
        wr(2'd2, 32'd7);
        step();
        chk("R8 timer sets bit 5", 32'(pend_bits), 32'h20);

        // R12: one increment; R11: compare write clears bit 5
        cnt_en = 1'b1; step(); cnt_en = 1'b0;
        rd(3'd3, v); chk("R12 count 8", v, 32'd8);
        wr(2'd2, 32'd100);
        chk("R11 compare write clears", 32'(pend_bits), 32'h0);

        // R12 counting and R8 with another index via counting into a match
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd11);
        cnt_en = 1'b1; step(); step(); step(); cnt_en = 1'b0;
        rd(3'd3, v); chk("R12 count 11", v, 32'd11);
        chk("R7 not yet set", 32'(pend_bits), 32'h0);
        step();
        chk("R8 timer sets bit 1", 32'(pend_bits), 32'h02);
        rd(3'd1, v); chk("R8 timer control read", v, 32'd1);
        rd(3'd4, v); chk("R9 pending read", v, 32'h02);

        // R12: count write beats increment
        cnt_en = 1'b1; wr(2'd3, 32'd50); cnt_en = 1'b0;
        rd(3'd3, v); chk("R12 write beats increment", v, 32'd50);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule